// File: doc/BRIEF.md
# Shift-Chain LIFO Stack

This block is a fixed-depth last-in first-out store of byte words, built as a chain of registers in which every level can load from its upper or lower neighbour. A processor core uses it for operand save and restore and for subroutine linkage. The top word is always visible on an output, so a value being pulled or exchanged is read in the same cycle that the request is made. A full indicator lets the core branch on the stack being full.

The stack never reports an error. A push onto a full stack loses the deepest word. A pull from a short or empty stack shifts zeros in from the bottom. A call saves a 16-bit return address as two words, and a return discards both. An exchange replaces only the top word. Requests arrive on separate strobes. At most one operation is performed per clock, chosen by a fixed priority.

Top module: `lifo_chain_top`

## Requirements
- R1: After a synchronous reset (`rst` high at a clock edge), every level and the occupancy count are zero, so `top_word` is 0, `ret_addr` is 0 and `full` is 0.
- R2: A push writes `wr_data` to the top level and moves every other level one place deeper. The count rises by one.
- R3: A push while the count equals DEPTH discards the deepest word. The count stays at DEPTH.
- R4: A pull moves every level one place toward the top and loads zero into the deepest level. The count falls by one but never below zero, so a pull on an empty stack leaves all levels zero.
- R5: An exchange writes `wr_data` to the top level. All other levels and the count are unchanged. The old top is the value shown on `top_word` in the request cycle.
- R6: A call puts `ret_in[7:0]` on the top level and `ret_in[15:8]` one level below it. Every older level moves two places deeper, and the count rises by two, saturating at DEPTH.
- R7: `ret_addr` always shows {level 1, level 0}. A return moves every level two places toward the top and loads zeros into the two deepest levels. The count falls by two, saturating at zero.
- R8: `full` is 1 exactly when the count equals DEPTH (default 16).
- R9: One operation is performed per clock. When several strobes are high, the order of priority is exchange, push, call, pull, return.
- R10: With no strobe high, all levels and the count hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| xchg_req | input | 1 | Exchange top with `wr_data` |
| push_req | input | 1 | Push `wr_data` |
| call_req | input | 1 | Save `ret_in` as two words |
| pull_req | input | 1 | Pull one word |
| ret_req | input | 1 | Discard two words |
| wr_data | input | 8 | Word to push or exchange |
| ret_in | input | 16 | Return address to save |
| top_word | output | 8 | Level 0 |
| ret_addr | output | 16 | {level 1, level 0} |
| full | output | 1 | Count equals DEPTH |

## Verification
Directed sequences cover specific corner cases:
- Pushing seventeen distinct words, then pulling all of them, shows that only the first word was dropped. This separates a correct drop-at-bottom from a wrap or a refused push.
- Pulls past empty check that zeros enter at the bottom and that the count does not wrap.
- Call and return pairs near the full boundary check the two-level shift and the saturation.
- Raising every strobe together checks the priority order.

A long random mix of strobes and data then compares every output against a bench model of the stack after each clock.

// File: rtl/lifo_pkg.sv
package lifo_pkg;
  typedef enum logic [2:0] {
    OP_IDLE = 3'd0,
    OP_XCHG = 3'd1,
    OP_PUSH = 3'd2,
    OP_CALL = 3'd3,
    OP_PULL = 3'd4,
    OP_RET  = 3'd5
  } stk_op_e;
endpackage

// File: rtl/lifo_arbiter.sv
module lifo_arbiter
  import lifo_pkg::*;
(
  input  logic    xchg_req,
  input  logic    push_req,
  input  logic    call_req,
  input  logic    pull_req,
  input  logic    ret_req,
  output stk_op_e op
);
  // fixed priority: exchange, push, call, pull, return (R9)
  always_comb begin
    if (xchg_req)      op = OP_XCHG;
    else if (push_req) op = OP_PUSH;
    else if (call_req) op = OP_CALL;
    else if (pull_req) op = OP_PULL;
    else if (ret_req)  op = OP_RET;
    else               op = OP_IDLE;
  end
endmodule

// File: rtl/lifo_levels.sv
module lifo_levels
  import lifo_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  stk_op_e          op,
  input  logic [WIDTH-1:0] wr_data,
  input  logic [2*WIDTH-1:0] ret_in,
  output logic [WIDTH-1:0] lvl0,
  output logic [WIDTH-1:0] lvl1
);
  localparam int LAST = DEPTH - 1;

  logic [WIDTH-1:0] lvl_q [DEPTH];
  logic [WIDTH-1:0] lvl_d [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_lvl
    // value arriving from above on a one- or two-place push
    logic [WIDTH-1:0] from_up1, from_up2, from_dn1, from_dn2;
    if (i == 0) begin : g_top
      assign from_up1 = wr_data;
      assign from_up2 = ret_in[WIDTH-1:0];
    end else if (i == 1) begin : g_second
      assign from_up1 = lvl_q[0];
      assign from_up2 = ret_in[2*WIDTH-1:WIDTH];
    end else begin : g_deep
      assign from_up1 = lvl_q[i-1];
      assign from_up2 = lvl_q[i-2];
    end
    if (i + 1 <= LAST) begin : g_has_dn1
      assign from_dn1 = lvl_q[i+1];
    end else begin : g_no_dn1
      assign from_dn1 = '0;
    end
    if (i + 2 <= LAST) begin : g_has_dn2
      assign from_dn2 = lvl_q[i+2];
    end else begin : g_no_dn2
      assign from_dn2 = '0;
    end

    always_comb begin
      unique case (op)
        OP_PUSH: lvl_d[i] = from_up1;
        OP_CALL: lvl_d[i] = from_up2;
        OP_PULL: lvl_d[i] = from_dn1;
        OP_RET:  lvl_d[i] = from_dn2;
        OP_XCHG: lvl_d[i] = (i == 0) ? wr_data : lvl_q[i];
        default: lvl_d[i] = lvl_q[i];
      endcase
    end

    always_ff @(posedge clk) begin
      if (rst) lvl_q[i] <= '0;
      else     lvl_q[i] <= lvl_d[i];
    end
  end

  assign lvl0 = lvl_q[0];
  assign lvl1 = lvl_q[1];

  assert_push_top_R2: assert property (@(posedge clk) disable iff (rst)
    op == OP_PUSH |=> lvl_q[0] == $past(wr_data) && lvl_q[1] == $past(lvl_q[0]));
  assert_pull_zero_fill_R4: assert property (@(posedge clk) disable iff (rst)
    op == OP_PULL |=> lvl_q[LAST] == '0);
  assert_xchg_keeps_rest_R5: assert property (@(posedge clk) disable iff (rst)
    op == OP_XCHG |=> $stable(lvl_q[1]) && $stable(lvl_q[LAST]));
  assert_call_split_R6: assert property (@(posedge clk) disable iff (rst)
    op == OP_CALL |=> {lvl_q[1], lvl_q[0]} == $past(ret_in));
  assert_ret_zero_fill_R7: assert property (@(posedge clk) disable iff (rst)
    op == OP_RET |=> lvl_q[LAST] == '0 && lvl_q[LAST-1] == '0);
endmodule

// File: rtl/lifo_occupancy.sv
module lifo_occupancy
  import lifo_pkg::*;
#(
  parameter int DEPTH = 16
) (
  input  logic    clk,
  input  logic    rst,
  input  stk_op_e op,
  output logic    full
);
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [CW-1:0] MAXC = CW'(DEPTH);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          full_q;

  always_comb begin
    cnt_d = cnt_q;
    unique case (op)
      OP_PUSH: cnt_d = (cnt_q == MAXC) ? MAXC : cnt_q + 1'b1;
      OP_CALL: cnt_d = (cnt_q >= MAXC - 1'b1) ? MAXC : cnt_q + 2'd2;
      OP_PULL: cnt_d = (cnt_q == '0) ? '0 : cnt_q - 1'b1;
      OP_RET:  cnt_d = (cnt_q < 2) ? '0 : cnt_q - 2'd2;
      default: cnt_d = cnt_q;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= '0;
      full_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      full_q <= (cnt_d == MAXC);
    end
  end

  assign full = full_q;

  assert_count_bound_R3: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= MAXC);
  assert_full_tracks_count_R8: assert property (@(posedge clk) disable iff (rst)
    full_q == (cnt_q == MAXC));
  assert_push_full_stays_R3: assert property (@(posedge clk) disable iff (rst)
    (op == OP_PUSH && full_q) |=> full_q);
  assert_idle_holds_R10: assert property (@(posedge clk) disable iff (rst)
    op == OP_IDLE |=> $stable(cnt_q));
endmodule

// File: rtl/lifo_chain_top.sv
module lifo_chain_top
  import lifo_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int WIDTH = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               xchg_req,
  input  logic               push_req,
  input  logic               call_req,
  input  logic               pull_req,
  input  logic               ret_req,
  input  logic [WIDTH-1:0]   wr_data,
  input  logic [2*WIDTH-1:0] ret_in,
  output logic [WIDTH-1:0]   top_word,
  output logic [2*WIDTH-1:0] ret_addr,
  output logic               full
);
  stk_op_e          op;
  logic [WIDTH-1:0] l0, l1;

  lifo_arbiter u_arb (
    .xchg_req(xchg_req), .push_req(push_req), .call_req(call_req),
    .pull_req(pull_req), .ret_req(ret_req), .op(op)
  );

  lifo_levels #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_lvl (
    .clk(clk), .rst(rst), .op(op), .wr_data(wr_data), .ret_in(ret_in),
    .lvl0(l0), .lvl1(l1)
  );

  lifo_occupancy #(.DEPTH(DEPTH)) u_occ (
    .clk(clk), .rst(rst), .op(op), .full(full)
  );

  assign top_word = l0;
  assign ret_addr = {l1, l0};

  // exchange beats push: level 1 must not take the old top
  assert_xchg_over_push_R9: assert property (@(posedge clk) disable iff (rst)
    (xchg_req && push_req) |=> top_word == $past(wr_data) &&
                               ret_addr[2*WIDTH-1:WIDTH] == $past(ret_addr[2*WIDTH-1:WIDTH]));
  assert_reset_clear_R1: assert property (@(posedge clk)
    rst |=> top_word == '0 && ret_addr == '0 && !full);
endmodule

// File: tb/tb_lifo_chain_top.sv
module tb_lifo_chain_top;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 16;

  logic        clk = 1'b0;
  logic        rst;
  logic        xchg_req, push_req, call_req, pull_req, ret_req;
  logic [7:0]  wr_data;
  logic [15:0] ret_in;
  logic [7:0]  top_word;
  logic [15:0] ret_addr;
  logic        full;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 0;

  logic [7:0] m [DEPTH];
  int         mcnt;

  always #(CLK_PERIOD/2) clk = ~clk;

  lifo_chain_top #(.DEPTH(DEPTH), .WIDTH(8)) dut (
    .clk(clk), .rst(rst), .xchg_req(xchg_req), .push_req(push_req),
    .call_req(call_req), .pull_req(pull_req), .ret_req(ret_req),
    .wr_data(wr_data), .ret_in(ret_in), .top_word(top_word),
    .ret_addr(ret_addr), .full(full)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // bench model: returns the requirement tag of the winning operation
  function automatic string model_step();
    if (rst) begin
      for (int i = 0; i < DEPTH; i++) m[i] = 8'h00;
      mcnt = 0;
      return "R1";
    end
    if (xchg_req) begin
      m[0] = wr_data;
      return (push_req || call_req || pull_req || ret_req) ? "R9" : "R5";
    end
    if (push_req) begin
      for (int i = DEPTH-1; i > 0; i--) m[i] = m[i-1];
      m[0] = wr_data;
      if (mcnt == DEPTH) return "R3";
      mcnt++;
      return "R2";
    end
    if (call_req) begin
      for (int i = DEPTH-1; i > 1; i--) m[i] = m[i-2];
      m[1] = ret_in[15:8];
      m[0] = ret_in[7:0];
      mcnt = (mcnt + 2 > DEPTH) ? DEPTH : mcnt + 2;
      return "R6";
    end
    if (pull_req) begin
      for (int i = 0; i < DEPTH-1; i++) m[i] = m[i+1];
      m[DEPTH-1] = 8'h00;
      mcnt = (mcnt == 0) ? 0 : mcnt - 1;
      return "R4";
    end
    if (ret_req) begin
      for (int i = 0; i < DEPTH-2; i++) m[i] = m[i+2];
      m[DEPTH-1] = 8'h00;
      m[DEPTH-2] = 8'h00;
      mcnt = (mcnt < 2) ? 0 : mcnt - 2;
      return "R7";
    end
    return "R10";
  endfunction

  task automatic drive(input logic r, input logic x, input logic p, input logic c,
                       input logic l, input logic t, input logic [7:0] d,
                       input logic [15:0] ra);
    string tag;
    rst = r; xchg_req = x; push_req = p; call_req = c; pull_req = l; ret_req = t;
    wr_data = d; ret_in = ra;
    @(posedge clk);
    #1;
    tag = model_step();
    chk(tag, 32'(top_word), 32'(m[0]));
    chk(tag, 32'(ret_addr), 32'({m[1], m[0]}));
    chk("R8", 32'(full), 32'(mcnt == DEPTH));
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h1d2c3b4a));
    rst = 1'b1; xchg_req = 0; push_req = 0; call_req = 0; pull_req = 0; ret_req = 0;
    wr_data = 0; ret_in = 0;
    for (int i = 0; i < DEPTH; i++) m[i] = 8'hxx;
    mcnt = 0;
    drive(1, 0, 0, 0, 0, 0, 8'h00, 16'h0000);
    drive(1, 0, 0, 0, 0, 0, 8'h00, 16'h0000);
    chk("R1", 32'(top_word), 32'h0);
    chk("R1", 32'(full), 32'h0);

    // R3: seventeen pushes, then drain; only word 1 must be gone
    for (int k = 1; k <= DEPTH + 1; k++) drive(0, 0, 1, 0, 0, 0, 8'(k), 16'h0);
    chk("R3", 32'(full), 32'h1);
    for (int k = DEPTH + 1; k >= 2; k--) begin
      chk("R3", 32'(top_word), 32'(k));
      drive(0, 0, 0, 0, 1, 0, 8'h00, 16'h0);
    end
    chk("R4", 32'(top_word), 32'h0);
    // R4: pulls past empty keep zeros, no wrap
    drive(0, 0, 0, 0, 1, 0, 8'h00, 16'h0);
    drive(0, 0, 0, 0, 1, 0, 8'h00, 16'h0);
    drive(0, 0, 1, 0, 0, 0, 8'h5a, 16'h0);
    chk("R4", 32'(full), 32'h0);

    // R6/R7: call, exchange, return
    drive(0, 0, 0, 1, 0, 0, 8'h00, 16'hbeef);
    chk("R6", 32'(ret_addr), 32'hbeef);
    drive(0, 1, 0, 0, 0, 0, 8'h77, 16'h0);
    chk("R5", 32'(ret_addr), 32'hbe77);
    drive(0, 0, 0, 0, 0, 1, 8'h00, 16'h0);
    chk("R7", 32'(top_word), 32'h5a);
    drive(0, 0, 0, 0, 0, 0, 8'h00, 16'h0);
    chk("R10", 32'(top_word), 32'h5a);

    // R6 saturation: calls onto a nearly full stack
    for (int k = 0; k < 9; k++) drive(0, 0, 0, 1, 0, 0, 8'h00, 16'(16'h1100 + k));
    chk("R6", 32'(full), 32'h1);
    for (int k = 0; k < 10; k++) drive(0, 0, 0, 0, 0, 1, 8'h00, 16'h0);
    chk("R7", 32'(ret_addr), 32'h0);

    // R9: all strobes together, then push beats the rest
    drive(0, 1, 1, 1, 1, 1, 8'hc3, 16'h1234);
    drive(0, 0, 1, 1, 1, 1, 8'h3c, 16'h1234);
    chk("R9", 32'(ret_addr), 32'hc33c);
    drive(0, 0, 0, 1, 1, 1, 8'h00, 16'hab12);
    chk("R9", 32'(ret_addr), 32'hab12);

    // random mix
    for (int n = 0; n < 3000; n++) begin
      int sel = $urandom_range(0, 99);
      drive(sel == 0, sel < 8 || sel > 96, sel >= 8 && sel < 40, sel >= 40 && sel < 52,
            sel >= 52 && sel < 80, sel >= 80 && sel < 90 || sel > 94,
            8'($urandom), 16'($urandom));
    end

    done = 1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule